// File: doc/BRIEF.md
# Time-Slot Anti-Collision Tag Controller

This controller sits on the tag side of a reader-tag link. It decides when the tag may answer so that many tags in one field rarely collide. The reader's commands arrive already decoded, as single-cycle strobes:

- a fast read request, which carries a slot-count code and a retransmit-count code;
- a fast read bypass;
- two matching codes;
- an end-process command.

When a request arrives, the controller draws a random slot delay below the requested slot limit. It then counts slot ticks until that delay has run out. At that point it asks the response path to start the fast-read answer, and it opens a listening window. A matching code received in the window sends the tag either to the sleeping loop or to the processing loop. If no code arrives, the controller answers again after a fresh random delay, as long as retransmits remain. When the retransmits run out, it returns to waiting for the next request.

Two configuration bits are sampled once, on the first cycle after reset:
- The fast-read-enable bit decides whether the detection loop is used at all.
- The talk-first bit decides whether the tag answers once on its own, without waiting for a request.

All pins are plain control and status signals. There is no data stream and no back-pressure. Every strobe is acted on in the cycle in which it is sampled, or it is dropped.

Top module: `tslot_tag_ctrl`

## Requirements
- R1: While reset is low, `resp_start_o` and `listen_o` are 0 and `loop_o` is 0 (idle). `loop_o` encodes 0 = idle, 1 = detection, 2 = processing, 3 = sleeping. When reset is released with `cfg_fast_rd_i`=1 and `cfg_talk_first_i`=0, `loop_o` reads 1 one cycle later, with no response started.
- R2: `frr_slots_i` selects the slot limit: 0 gives 1, 1 gives 16, 2 or 3 give 64. The response starts after k slot ticks, where k lies between 0 and the limit minus 1. With a limit of 1, `resp_start_o` is high in the second cycle after the edge that samples the request.
- R3: `frr_tx_i` selects the retransmit limit: 0 gives 1, 1 gives 2, 2 or 3 give 4. With a slot limit of 1 and no matching code, exactly that many responses are started, each LISTEN_CYC+1 cycles after the previous one. After the last one, the controller waits in detection with `listen_o` low.
- R4: `listen_o` rises in the same cycle as each `resp_start_o` pulse and stays high for exactly LISTEN_CYC cycles.
- R5: A matching code sampled while `listen_o` is high moves `loop_o` one cycle later: code 1 (`mc1_i`) to 3, code 2 (`mc2_i`) to 2. Matching codes sampled outside the window have no effect.
- R6: In processing, `ep_i` moves `loop_o` to 3 one cycle later. Requests, bypasses and matching codes have no effect there.
- R7: Sleeping ignores every command until reset: `loop_o` stays 3 and no response or window starts.
- R8: With `cfg_fast_rd_i`=1 and `cfg_talk_first_i`=1, one response starts in the second cycle after reset release, without a request. No retransmit follows it. A later request re-enables retransmits up to the retransmit limit.
- R9: With `cfg_fast_rd_i`=0, the state is idle and requests and matching codes are ignored. A bypass starts a response in the cycle after it is sampled and opens a window. In that window `mc2_i` moves the state to processing, and a timeout returns the state to idle.
- R10: With `cfg_fast_rd_i`=1, a bypass has no effect.
- R11: `resp_start_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| cfg_fast_rd_i | input | 1 | Configuration: detection loop enabled |
| cfg_talk_first_i | input | 1 | Configuration: answer once without a request |
| frr_i | input | 1 | Fast read request strobe |
| frr_slots_i | input | 2 | Slot-limit code of the request |
| frr_tx_i | input | 2 | Retransmit-limit code of the request |
| frb_i | input | 1 | Fast read bypass strobe |
| mc1_i | input | 1 | Matching code 1 strobe (go to sleep) |
| mc2_i | input | 1 | Matching code 2 strobe (go to processing) |
| ep_i | input | 1 | End-process strobe |
| slot_tick_i | input | 1 | One pulse per elapsed time slot |
| rng_i | input | 6 | External entropy mixed into the slot draw |
| resp_start_o | output | 1 | One-cycle request to start the response |
| listen_o | output | 1 | Listening window open |
| loop_o | output | 2 | Current loop (0 idle, 1 detection, 2 processing, 3 sleeping) |

## Verification
Each output has a fixed latency from the stimulus:
- A request with a slot limit of 1 raises `resp_start_o` two edges after its own sample edge. A bypass raises it one edge after.
- Matching codes and end process change `loop_o` one edge after they are sampled.
- Retransmits follow each other every LISTEN_CYC+1 cycles.

The bench drives strobes on falling edges and reads the outputs on the next falling edge, so each result is checked in the exact cycle it is due. The slot draw is random, so for limits 16 and 64 the bench counts the slot ticks it delivered before the response appeared and bounds that count by the limit minus 1.

// File: rtl/tslot_pkg.sv
`timescale 1ns/1ps
package tslot_pkg;
  localparam int SLOT_W = 6;
  localparam int TX_W   = 3;

  typedef enum logic [1:0] {
    LOOP_IDLE    = 2'd0,
    LOOP_DETECT  = 2'd1,
    LOOP_PROCESS = 2'd2,
    LOOP_SLEEP   = 2'd3
  } loop_e;

  typedef enum logic [2:0] {
    PH_BOOT, PH_IDLE, PH_WAIT, PH_SLOT, PH_LISTEN, PH_PROC, PH_SLEEP
  } phase_e;

  // slot-limit code -> mask (limit - 1)
  function automatic logic [SLOT_W-1:0] slot_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    slot_mask = SLOT_W'(0);
      2'd1:    slot_mask = SLOT_W'(15);
      default: slot_mask = SLOT_W'(63);
    endcase
  endfunction

  // retransmit-limit code -> number of responses
  function automatic logic [TX_W-1:0] tx_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    tx_limit = TX_W'(1);
      2'd1:    tx_limit = TX_W'(2);
      default: tx_limit = TX_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/tslot_rng.sv
`timescale 1ns/1ps
module tslot_rng #(
  parameter int W = 6,
  parameter logic [W-1:0] TAPS = 6'b110000,
  parameter logic [W-1:0] SEED = 6'h2D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mix_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] draw_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               state_q <= SEED;
    else if (state_q == '0)   state_q <= SEED;
    else                      state_q <= {state_q[W-2:0], fb};
  end

  assign draw_o = (state_q ^ mix_i) & mask_i;

  // R2
  property lfsr_live_p;
    @(posedge clk) disable iff (!rst_n) state_q != '0;
  endproperty
  lfsr_live_chk: assert property (lfsr_live_p);
endmodule

// File: rtl/tslot_slot_timer.sv
`timescale 1ns/1ps
module tslot_slot_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         zero_o
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        left_q <= '0;
    else if (load_i)                   left_q <= val_i;
    else if (tick_i && left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign zero_o = (left_q == '0);

  // R2
  property no_grow_p;
    @(posedge clk) disable iff (!rst_n) !load_i |=> left_q <= $past(left_q);
  endproperty
  no_grow_chk: assert property (no_grow_p);
endmodule

// File: rtl/tslot_win_timer.sv
`timescale 1ns/1ps
module tslot_win_timer #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] TOP = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (start_i)                cnt_q <= TOP;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0);

  // R4
  property win_range_p;
    @(posedge clk) disable iff (!rst_n) cnt_q <= TOP;
  endproperty
  win_range_chk: assert property (win_range_p);
endmodule

// File: rtl/tslot_tag_ctrl.sv
`timescale 1ns/1ps
module tslot_tag_ctrl
  import tslot_pkg::*;
#(
  parameter int LISTEN_CYC = 8,
  parameter logic [SLOT_W-1:0] RNG_SEED = 6'h2D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fast_rd_i,
  input  logic              cfg_talk_first_i,
  input  logic              frr_i,
  input  logic [1:0]        frr_slots_i,
  input  logic [1:0]        frr_tx_i,
  input  logic              frb_i,
  input  logic              mc1_i,
  input  logic              mc2_i,
  input  logic              ep_i,
  input  logic              slot_tick_i,
  input  logic [SLOT_W-1:0] rng_i,
  output logic              resp_start_o,
  output logic              listen_o,
  output logic [1:0]        loop_o
);
  phase_e            phase_q, phase_d;
  logic              bypass_q, bypass_d;
  logic              pos1_q, pos1_d;
  logic              resp_q, resp_d;
  logic [TX_W-1:0]   tc_lim_q, tc_lim_d, tx_cnt_q, tx_cnt_d;
  logic [SLOT_W-1:0] ts_mask_q, ts_mask_d, rng_mask, draw, load_val;
  logic              load_slot, slot_zero, win_start, win_run, win_expire;
  logic              restart;

  assign rng_mask = frr_i ? slot_mask(frr_slots_i) : ts_mask_q;

  tslot_rng #(.W(SLOT_W), .SEED(RNG_SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .mix_i(rng_i), .mask_i(rng_mask), .draw_o(draw)
  );

  tslot_slot_timer #(.W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load_i(load_slot), .val_i(load_val),
    .tick_i(slot_tick_i), .zero_o(slot_zero)
  );

  assign win_run = (phase_q == PH_LISTEN);

  tslot_win_timer #(.CYC(LISTEN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(win_start), .run_i(win_run),
    .expire_o(win_expire)
  );

  always_comb begin
    phase_d   = phase_q;
    bypass_d  = bypass_q;
    pos1_d    = pos1_q;
    tc_lim_d  = tc_lim_q;
    tx_cnt_d  = tx_cnt_q;
    ts_mask_d = ts_mask_q;
    resp_d    = 1'b0;
    win_start = 1'b0;
    load_slot = 1'b0;
    load_val  = draw;
    restart   = 1'b0;
    case (phase_q)
      PH_BOOT: begin
        if (!cfg_fast_rd_i) phase_d = PH_IDLE;
        else if (cfg_talk_first_i) begin
          phase_d   = PH_SLOT;
          load_slot = 1'b1;
          load_val  = '0;
          tc_lim_d  = TX_W'(1);
          tx_cnt_d  = '0;
        end else phase_d = PH_WAIT;
      end
      PH_IDLE: begin
        if (frb_i) begin
          phase_d   = PH_LISTEN;
          bypass_d  = 1'b1;
          resp_d    = 1'b1;
          win_start = 1'b1;
        end
      end
      PH_WAIT: restart = frr_i;
      PH_SLOT: begin
        if (frr_i) restart = 1'b1;
        else if (slot_zero) begin
          phase_d   = PH_LISTEN;
          resp_d    = 1'b1;
          win_start = 1'b1;
          tx_cnt_d  = tx_cnt_q + 1'b1;
        end
      end
      PH_LISTEN: begin
        if (mc1_i) begin
          phase_d  = PH_SLEEP;
          bypass_d = 1'b0;
        end else if (mc2_i) begin
          phase_d  = PH_PROC;
          bypass_d = 1'b0;
        end else if (frr_i && !bypass_q) restart = 1'b1;
        else if (win_expire) begin
          if (bypass_q) begin
            phase_d  = PH_IDLE;
            bypass_d = 1'b0;
          end else if (!pos1_q && tx_cnt_q < tc_lim_q) begin
            phase_d   = PH_SLOT;
            load_slot = 1'b1;
          end else phase_d = PH_WAIT;
        end
      end
      PH_PROC:  if (ep_i) phase_d = PH_SLEEP;
      default:  phase_d = phase_q;
    endcase
    if (restart) begin
      phase_d   = PH_SLOT;
      pos1_d    = 1'b0;
      tc_lim_d  = tx_limit(frr_tx_i);
      ts_mask_d = slot_mask(frr_slots_i);
      tx_cnt_d  = '0;
      load_slot = 1'b1;
      load_val  = draw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_BOOT;
      bypass_q  <= 1'b0;
      pos1_q    <= 1'b1;
      resp_q    <= 1'b0;
      tc_lim_q  <= TX_W'(1);
      tx_cnt_q  <= '0;
      ts_mask_q <= '0;
    end else begin
      phase_q   <= phase_d;
      bypass_q  <= bypass_d;
      pos1_q    <= pos1_d;
      resp_q    <= resp_d;
      tc_lim_q  <= tc_lim_d;
      tx_cnt_q  <= tx_cnt_d;
      ts_mask_q <= ts_mask_d;
    end
  end

  always_comb begin
    case (phase_q)
      PH_WAIT, PH_SLOT: loop_o = LOOP_DETECT;
      PH_LISTEN:        loop_o = bypass_q ? LOOP_IDLE : LOOP_DETECT;
      PH_PROC:          loop_o = LOOP_PROCESS;
      PH_SLEEP:         loop_o = LOOP_SLEEP;
      default:          loop_o = LOOP_IDLE;
    endcase
  end

  assign resp_start_o = resp_q;
  assign listen_o     = (phase_q == PH_LISTEN);

  // R11
  property resp_pulse_p;
    @(posedge clk) disable iff (!rst_n) resp_start_o |=> !resp_start_o;
  endproperty
  resp_pulse_chk: assert property (resp_pulse_p);

  // R4
  property resp_opens_win_p;
    @(posedge clk) disable iff (!rst_n) resp_start_o |-> listen_o;
  endproperty
  resp_opens_win_chk: assert property (resp_opens_win_p);

  // R7
  property sleep_hold_p;
    @(posedge clk) disable iff (!rst_n) loop_o == LOOP_SLEEP |=> loop_o == LOOP_SLEEP;
  endproperty
  sleep_hold_chk: assert property (sleep_hold_p);

  // R5
  property proc_entry_p;
    @(posedge clk) disable iff (!rst_n) $rose(loop_o == LOOP_PROCESS) |-> $past(listen_o);
  endproperty
  proc_entry_chk: assert property (proc_entry_p);

  // R6
  property ep_exit_p;
    @(posedge clk) disable iff (!rst_n) (loop_o == LOOP_PROCESS && ep_i) |=> loop_o == LOOP_SLEEP;
  endproperty
  ep_exit_chk: assert property (ep_exit_p);

  // R3
  property tx_bound_p;
    @(posedge clk) disable iff (!rst_n) tx_cnt_q <= tc_lim_q;
  endproperty
  tx_bound_chk: assert property (tx_bound_p);
endmodule

// File: tb/tslot_tag_ctrl_tb.sv
`timescale 1ns/1ps
module tslot_tag_ctrl_tb;
  localparam int LW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_fr = 1'b0, cfg_tf = 1'b0;
  logic       frr = 1'b0, frb = 1'b0, mc1 = 1'b0, mc2 = 1'b0, ep = 1'b0, tick = 1'b0;
  logic [1:0] slots = 2'd0, txs = 2'd0;
  logic [5:0] rng = 6'd0;
  logic       resp, listen;
  logic [1:0] loop;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int w_cnt, w_first, w_gapbad, w_listen, w_dbl;

  always #2.5 clk = ~clk;

  tslot_tag_ctrl #(.LISTEN_CYC(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fast_rd_i(cfg_fr), .cfg_talk_first_i(cfg_tf),
    .frr_i(frr), .frr_slots_i(slots), .frr_tx_i(txs), .frb_i(frb),
    .mc1_i(mc1), .mc2_i(mc2), .ep_i(ep), .slot_tick_i(tick), .rng_i(rng),
    .resp_start_o(resp), .listen_o(listen), .loop_o(loop)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic fr, input logic tf);
    rst_n = 1'b0; cfg_fr = fr; cfg_tf = tf;
    frr = 0; frb = 0; mc1 = 0; mc2 = 0; ep = 0; tick = 0;
    repeat (3) step();
    chk(resp == 0 && listen == 0 && loop == 2'd0, "R1 reset outputs", {resp, listen, loop}, 0);
    rst_n = 1'b1;
  endtask

  task automatic pulse_frr(input logic [1:0] s, input logic [1:0] t);
    slots = s; txs = t; frr = 1'b1;
    step();
    frr = 1'b0;
  endtask

  task automatic watch(input int n);
    int last;
    logic prev;
    w_cnt = 0; w_first = -1; w_gapbad = 0; w_listen = 0; w_dbl = 0;
    last = -1; prev = 1'b0;
    for (int i = 1; i <= n; i++) begin
      step();
      if (listen) w_listen++;
      if (resp) begin
        if (prev) w_dbl++;
        w_cnt++;
        if (w_first < 0) w_first = i;
        else if (i - last != LW + 1) w_gapbad++;
        last = i;
      end
      prev = resp;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lim, ticks, found;
    // reader-talks-first start
    do_reset(1'b1, 1'b0);
    step();
    chk(loop == 2'd1 && !listen && !resp, "R1 detection after boot", loop, 1);

    // sweep of retransmit codes with slot limit 1
    for (int t = 0; t < 4; t++) begin
      lim = (t == 0) ? 1 : (t == 1) ? 2 : 4;
      pulse_frr(2'd0, t[1:0]);
      watch(5 * (LW + 1) + 4);
      chk(w_first == 1, "R2 latency with slot limit 1", w_first, 1);
      chk(w_cnt == lim, "R3 response count", w_cnt, lim);
      chk(w_gapbad == 0, "R3 retransmit spacing", w_gapbad, 0);
      chk(w_listen == lim * LW, "R4 window length", w_listen, lim * LW);
      chk(w_dbl == 0, "R11 single-cycle pulse", w_dbl, 0);
      chk(loop == 2'd1 && !listen, "R3 back to waiting", loop, 1);
    end

    // random slot delay bound for limits 16 and 64
    for (int s = 1; s <= 2; s++) begin
      lim = (s == 1) ? 16 : 64;
      for (int r = 0; r < 8; r++) begin
        rng = 6'(r * 9 + s);
        pulse_frr(s[1:0], 2'd0);
        ticks = 0; found = 0;
        for (int c = 0; c < lim * 3 + 10 && !found; c++) begin
          tick = (c % 3 == 2);
          step();
          if (resp) found = 1;
          else if (tick) ticks++;
          tick = 1'b0;
        end
        chk(found == 1 && ticks <= lim - 1, "R2 slot delay within limit", ticks, lim - 1);
        watch(LW + 3);
      end
    end

    // matching code outside the window
    mc2 = 1'b1; step(); mc2 = 1'b0;
    chk(loop == 2'd1, "R5 code outside window ignored", loop, 1);

    // matching code 2 -> processing, then end process
    pulse_frr(2'd0, 2'd3);
    step(); step();
    mc2 = 1'b1; step(); mc2 = 1'b0;
    chk(loop == 2'd2, "R5 code 2 to processing", loop, 2);
    frr = 1'b1; mc1 = 1'b1; frb = 1'b1; step(); frr = 0; mc1 = 0; frb = 0;
    watch(3 * LW);
    chk(w_cnt == 0 && loop == 2'd2, "R6 processing ignores others", loop, 2);
    ep = 1'b1; step(); ep = 1'b0;
    chk(loop == 2'd3, "R6 end process to sleep", loop, 3);
    frr = 1'b1; mc2 = 1'b1; ep = 1'b1; frb = 1'b1; step(); frr = 0; mc2 = 0; ep = 0; frb = 0;
    watch(30);
    chk(w_cnt == 0 && w_listen == 0 && loop == 2'd3, "R7 sleep ignores commands", loop, 3);

    // matching code 1 in second window
    do_reset(1'b1, 1'b0);
    step();
    pulse_frr(2'd0, 2'd2);
    watch(LW + 3);
    chk(w_cnt == 2, "R3 two responses before match", w_cnt, 2);
    mc1 = 1'b1; step(); mc1 = 1'b0;
    chk(loop == 2'd3, "R5 code 1 to sleep", loop, 3);
    watch(40);
    chk(w_cnt == 0, "R7 no response while sleeping", w_cnt, 0);

    // tag-talks-first
    do_reset(1'b1, 1'b1);
    watch(3 * (LW + 1) + 5);
    chk(w_first == 2, "R8 unsolicited response timing", w_first, 2);
    chk(w_cnt == 1, "R8 no retransmit before request", w_cnt, 1);
    chk(loop == 2'd1, "R8 waits in detection", loop, 1);
    pulse_frr(2'd0, 2'd1);
    watch(3 * (LW + 1) + 5);
    chk(w_cnt == 2, "R8 request re-enables retransmit", w_cnt, 2);

    // detection disabled
    do_reset(1'b0, 1'b0);
    step();
    chk(loop == 2'd0, "R9 idle when detection disabled", loop, 0);
    pulse_frr(2'd0, 2'd0);
    mc2 = 1'b1; step(); mc2 = 1'b0;
    watch(20);
    chk(w_cnt == 0 && loop == 2'd0, "R9 request and code ignored", loop, 0);
    frb = 1'b1; step(); frb = 1'b0;
    chk(resp == 1 && listen == 1, "R9 bypass response", {resp, listen}, 3);
    watch(LW + 3);
    chk(w_cnt == 0 && loop == 2'd0 && !listen, "R9 bypass timeout to idle", loop, 0);
    frb = 1'b1; step(); frb = 1'b0;
    step();
    mc2 = 1'b1; step(); mc2 = 1'b0;
    chk(loop == 2'd2, "R9 bypass then code 2", loop, 2);

    // bypass with detection enabled
    do_reset(1'b1, 1'b0);
    step();
    frb = 1'b1; step(); frb = 1'b0;
    watch(20);
    chk(w_cnt == 0 && loop == 2'd1, "R10 bypass ignored", w_cnt, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule